// File: doc/BRIEF.md
# Two-Dice Craps Game Controller

This block plays a craps-style game with two electronic dice. Each die is a counter that steps through the faces one to six. The second die steps once each time the first one passes from six back to one. The dice move only while the player holds the roll button. Whatever faces are showing when the button is released form the roll. An adder produces the sum, and compare logic raises flags for a seven, a natural (seven or eleven), craps (two, three or twelve) and a match with the stored point.

Two linked state machines run on one clock. The game machine has four states: first roll, later roll, win and lose. In each of the two rolling states it enables a small roll machine and waits for that machine's done pulse before it judges the sum. The roll machine leaves idle when it is enabled and the button is down. It drives the dice while the button stays down, then raises done and goes back to idle on release. From the win or lose state, only the new-game input starts another game. The dice faces carry over from one game to the next.

Top module: `dice_game`

## Requirements
- R1: While `rst_n` is low, and just after it rises, die A and die B both read 1, the sum reads 2, and the win and lose lights are off.
- R2: Die A advances by one on each rolling cycle and goes from 6 back to 1. Die B advances only on a cycle in which die A goes from 6 to 1, and it also goes from 6 back to 1. The sum output always equals die A plus die B.
- R3: The dice move only while the roll button is held during a first-roll or later-roll phase. Holding the button for H clock cycles moves the dice by H-1 steps, because the first cycle only moves the roll machine out of idle. The faces showing on release are the roll.
- R4: On the first roll of a game, a sum of 7 or 11 turns on the win light on the cycle after the release.
- R5: On the first roll of a game, a sum of 2, 3 or 12 turns on the lose light on the cycle after the release.
- R6: On the first roll, any other sum is stored as the point. Both lights stay off and the game moves to later rolls.
- R7: On a later roll, a sum equal to the stored point turns on the win light.
- R8: On a later roll, a sum of 7 turns on the lose light. Any other sum leaves both lights off and waits for another roll.
- R9: Win and lose are never on together. Once either is on, it stays on and the dice stay frozen even if the roll button is pressed, until a new game is requested.
- R10: A `new_game` pulse while a light is on returns the game to the first-roll phase with both lights off and the dice unchanged. In the first-roll or later-roll phase, `new_game` has no effect on the lights or on the outcome of the next roll.
- R11: No verdict is given while the button is held. Both lights stay off on every cycle that follows a cycle with the button down and no light on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both machines |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| roll_btn | input | 1 | Debounced, synchronized roll button, high while pressed |
| new_game | input | 1 | Synchronous request to leave the win or lose state |
| win | output | 1 | Win light |
| lose | output | 1 | Lose light |
| die_a | output | 3 | Face of the first die, 1 to 6 |
| die_b | output | 3 | Face of the second die, 1 to 6 |
| sum | output | 4 | Sum of the two faces, 2 to 12 |

## Verification
The hardest situation to reach from the ports is a chosen pair of faces, because the dice can only be moved by holding the button, and every step is also a game move. The bench tracks a linear position from 0 to 35 across both dice. From that position it works out exactly how many cycles to hold the button to land on a target pair, counting the one cycle the roll machine spends leaving idle. This lets it hit each natural, each craps value, a stored point, a miss, a matching point and a losing seven in turn. The same stepping drives both dice through the double wrap from (5,6) to (1,1).

// File: rtl/dice_pkg.sv
package dice_pkg;
    localparam int FACES    = 6;
    localparam int NUM_DICE = 2;
    localparam int DIE_W    = $clog2(FACES + 1);
    localparam int SUM_W    = $clog2(NUM_DICE * FACES + 1);

    localparam int SUM_SEVEN  = FACES + 1;
    localparam int SUM_ELEVEN = 2 * FACES - 1;
    localparam int SUM_SNAKE  = 2;
    localparam int SUM_TREY   = 3;
    localparam int SUM_BOXCAR = 2 * FACES;

    typedef enum logic [1:0] {
        G_FIRST = 2'd0,
        G_LATER = 2'd1,
        G_WIN   = 2'd2,
        G_LOSE  = 2'd3
    } game_st_e;

    typedef enum logic {
        R_IDLE  = 1'b0,
        R_SPIN  = 1'b1
    } roll_st_e;

    typedef struct packed {
        logic seven;
        logic natural;
        logic craps;
        logic match;
    } sum_flags_t;

    typedef struct packed {
        game_st_e             st;
        logic [SUM_W-1:0]     point;
    } game_regs_t;
endpackage

// File: rtl/die_counter.sv
module die_counter
    import dice_pkg::*;
#(
    parameter int N_FACES = FACES,
    parameter int W       = DIE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] face
);
    logic [W-1:0] face_d, face_q;

    always_comb begin
        face_d = face_q;
        if (step) begin
            if (face_q == W'(N_FACES)) face_d = W'(1);
            else                       face_d = face_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) face_q <= W'(1);
        else        face_q <= face_d;
    end

    assign face = face_q;
endmodule

// File: rtl/dice_bank.sv
module dice_bank
    import dice_pkg::*;
#(
    parameter int N_DICE = NUM_DICE
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               roll,
    output logic [N_DICE-1:0][DIE_W-1:0]       faces,
    output logic [SUM_W-1:0]                   total
);
    logic [N_DICE-1:0] step;

    for (genvar i = 0; i < N_DICE; i++) begin : g_die
        if (i == 0) begin : g_head
            assign step[i] = roll;
        end else begin : g_tail
            assign step[i] = step[i-1] && (faces[i-1] == DIE_W'(FACES));
        end
        die_counter #(.N_FACES(FACES), .W(DIE_W)) u_die (
            .clk  (clk),
            .rst_n(rst_n),
            .step (step[i]),
            .face (faces[i])
        );
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < N_DICE; i++) begin
            total = total + SUM_W'(faces[i]);
        end
    end
endmodule

// File: rtl/sum_judge.sv
module sum_judge
    import dice_pkg::*;
(
    input  logic [SUM_W-1:0] total,
    input  logic [SUM_W-1:0] point,
    output sum_flags_t       flags
);
    always_comb begin
        flags.seven   = (total == SUM_W'(SUM_SEVEN));
        flags.natural = (total == SUM_W'(SUM_SEVEN)) || (total == SUM_W'(SUM_ELEVEN));
        flags.craps   = (total == SUM_W'(SUM_SNAKE)) || (total == SUM_W'(SUM_TREY))
                     || (total == SUM_W'(SUM_BOXCAR));
        flags.match   = (total == point);
    end
endmodule

// File: rtl/roll_ctrl.sv
module roll_ctrl
    import dice_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic enable,
    input  logic button,
    output logic roll,
    output logic done
);
    roll_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        roll = 1'b0;
        done = 1'b0;
        unique case (st_q)
            R_IDLE: begin
                if (enable && button) st_d = R_SPIN;
            end
            R_SPIN: begin
                if (button) begin
                    roll = 1'b1;
                end else begin
                    done = 1'b1;
                    st_d = R_IDLE;
                end
            end
            default: st_d = R_IDLE;
        endcase
        if (abort) st_d = R_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= R_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/game_ctrl.sv
module game_ctrl
    import dice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_game,
    input  logic             roll_done,
    input  sum_flags_t       flags,
    input  logic [SUM_W-1:0] total,
    output logic             roll_en,
    output logic [SUM_W-1:0] point,
    output logic             win,
    output logic             lose
);
    game_regs_t r_d, r_q;
    logic       keep_point;

    always_comb begin
        r_d        = r_q;
        keep_point = 1'b0;
        unique case (r_q.st)
            G_FIRST: begin
                if (roll_done) begin
                    if (flags.natural)    r_d.st = G_WIN;
                    else if (flags.craps) r_d.st = G_LOSE;
                    else begin
                        keep_point = 1'b1;
                        r_d.st     = G_LATER;
                    end
                end
            end
            G_LATER: begin
                if (roll_done) begin
                    if (flags.match)      r_d.st = G_WIN;
                    else if (flags.seven) r_d.st = G_LOSE;
                end
            end
            G_WIN, G_LOSE: begin
                if (new_game) r_d.st = G_FIRST;
            end
            default: r_d.st = G_FIRST;
        endcase
        if (keep_point) r_d.point = total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: G_FIRST, point: '0};
        else        r_q <= r_d;
    end

    assign roll_en = (r_q.st == G_FIRST) || (r_q.st == G_LATER);
    assign point   = r_q.point;
    assign win     = (r_q.st == G_WIN);
    assign lose    = (r_q.st == G_LOSE);
endmodule

// File: rtl/dice_game.sv
module dice_game
    import dice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roll_btn,
    input  logic             new_game,
    output logic             win,
    output logic             lose,
    output logic [DIE_W-1:0] die_a,
    output logic [DIE_W-1:0] die_b,
    output logic [SUM_W-1:0] sum
);
    logic                          roll_en;
    logic                          roll_done;
    logic                          rolling;
    logic [NUM_DICE-1:0][DIE_W-1:0] faces;
    logic [SUM_W-1:0]              total;
    logic [SUM_W-1:0]              point;
    sum_flags_t                    flags;

    roll_ctrl u_roll (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (new_game),
        .enable(roll_en),
        .button(roll_btn),
        .roll  (rolling),
        .done  (roll_done)
    );

    dice_bank #(.N_DICE(NUM_DICE)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .roll (rolling),
        .faces(faces),
        .total(total)
    );

    sum_judge u_judge (
        .total(total),
        .point(point),
        .flags(flags)
    );

    game_ctrl u_game (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_game (new_game),
        .roll_done(roll_done),
        .flags    (flags),
        .total    (total),
        .roll_en  (roll_en),
        .point    (point),
        .win      (win),
        .lose     (lose)
    );

    assign die_a = faces[0];
    assign die_b = faces[1];
    assign sum   = total;
endmodule

// File: rtl/dice_game_chk.sv
module dice_game_chk
    import dice_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             roll_btn,
    input logic             new_game,
    input logic             win,
    input logic             lose,
    input logic [DIE_W-1:0] die_a,
    input logic [DIE_W-1:0] die_b,
    input logic [SUM_W-1:0] sum
);
    AST_FACE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (die_a >= DIE_W'(1)) && (die_a <= DIE_W'(FACES)) &&
        (die_b >= DIE_W'(1)) && (die_b <= DIE_W'(FACES))); // R2

    AST_B_ON_A_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(die_b) |-> (($past(die_a) == DIE_W'(FACES)) && (die_a == DIE_W'(1)))); // R2

    AST_MOVE_NEEDS_BUTTON: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(die_a) |-> $past(roll_btn)); // R3

    AST_LIGHTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(win && lose)); // R9

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !new_game) |=> (win && $stable(die_a) && $stable(die_b))); // R9

    AST_LOSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lose && !new_game) |=> (lose && $stable(die_a) && $stable(die_b))); // R9

    AST_NEW_GAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((win || lose) && new_game) |=> (!win && !lose)); // R10

    AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_btn && !win && !lose) |=> (!win && !lose)); // R11

    logic unused_sum;
    assign unused_sum = ^sum;
endmodule

bind dice_game dice_game_chk u_chk (.*);

// File: tb/dice_game_bench.sv
module dice_game_bench;
    import dice_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             roll_btn = 1'b0;
    logic             new_game = 1'b0;
    logic             win, lose;
    logic [DIE_W-1:0] die_a, die_b;
    logic [SUM_W-1:0] sum;

    int checks = 0;
    int errors = 0;
    int pos = 0;      // linear dice position: (a-1) + 6*(b-1)
    int phase = 0;    // 0 first, 1 later, 2 win, 3 lose
    int point_m = 0;
    bit done_run = 1'b0;

    dice_game u_dice_game (
        .clk(clk), .rst_n(rst_n), .roll_btn(roll_btn), .new_game(new_game),
        .win(win), .lose(lose), .die_a(die_a), .die_b(die_b), .sum(sum)
    );

    always #4 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "die_a", int'(die_a), pos % FACES + 1);
        check(req, "die_b", int'(die_b), pos / FACES + 1);
        check(req, "sum",   int'(sum),   pos % FACES + pos / FACES + 2);
        check(req, "win",   int'(win),   (phase == 2) ? 1 : 0);
        check(req, "lose",  int'(lose),  (phase == 3) ? 1 : 0);
    endtask

    task automatic judge(int s);
        if (phase == 0) begin
            if (s == 7 || s == 11) phase = 2;
            else if (s == 2 || s == 3 || s == 12) phase = 3;
            else begin point_m = s; phase = 1; end
        end else if (phase == 1) begin
            if (s == point_m) phase = 2;
            else if (s == 7) phase = 3;
        end
    endtask

    // hold the button for n+1 cycles: one to leave idle, n dice steps
    task automatic roll_to(int a, int b, string req);
        int target = (a - 1) + FACES * (b - 1);
        int n = (target - pos + FACES * FACES) % (FACES * FACES);
        roll_btn = 1'b1;
        repeat (n + 1) @(negedge clk);
        roll_btn = 1'b0;
        @(negedge clk);
        pos = target;
        judge(a + b);
        check_all(req);
    endtask

    task automatic pulse_new_game(string req);
        new_game = 1'b1;
        @(negedge clk);
        new_game = 1'b0;
        if (phase >= 2) phase = 0;
        check_all(req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_idle_no_move;
        repeat (10) @(negedge clk);
        check_all("R3");
    endtask

    task automatic t_naturals;
        roll_to(1, 6, "R4");
        pulse_new_game("R10");
        roll_to(5, 6, "R4");
        pulse_new_game("R10");
    endtask

    task automatic t_craps;
        roll_to(1, 1, "R2");   // both dice wrap from (5,6), sum 2 loses
        check(" R5", "lose after snake eyes", int'(lose), 1);
        pulse_new_game("R10");
        roll_to(2, 1, "R5");
        pulse_new_game("R10");
        roll_to(6, 6, "R5");
        pulse_new_game("R10");
    endtask

    task automatic t_point_win;
        roll_to(2, 2, "R6");
        check("R6", "phase later", phase, 1);
        roll_to(3, 2, "R8");
        roll_to(1, 3, "R7");
        pulse_new_game("R10");
    endtask

    task automatic t_point_seven;
        roll_to(6, 2, "R6");
        roll_to(4, 3, "R8");
    endtask

    task automatic t_frozen_in_lose;
        roll_btn = 1'b1;
        repeat (10) @(negedge clk);
        check_all("R9");
        roll_btn = 1'b0;
        repeat (5) @(negedge clk);
        check_all("R9");
        pulse_new_game("R10");
    endtask

    task automatic t_held_no_verdict;
        roll_btn = 1'b1;
        repeat (5) @(negedge clk);
        check("R11", "win while held", int'(win), 0);
        check("R11", "lose while held", int'(lose), 0);
        check("R3", "die_a while held", int'(die_a), (pos + 4) % FACES + 1);
        roll_btn = 1'b0;
        @(negedge clk);
        pos = pos + 4;
        judge(pos % FACES + pos / FACES + 2);
        check_all("R3");
    endtask

    task automatic t_new_game_ignored;
        pulse_new_game("R10");
        check("R10", "phase kept", phase, 1);
        roll_to(1, 5, "R10");
        check("R7", "win on point after ignored new_game", int'(win), 1);
    endtask

    initial begin
        t_reset();
        t_idle_no_move();
        t_naturals();
        t_craps();
        t_point_win();
        t_point_seven();
        t_frozen_in_lose();
        t_held_no_verdict();
        t_new_game_ignored();
        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule